// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Filtering

This block is the receive half of an asynchronous serial port for shared multi-drop lines such as RS-485. It watches a serial input using an externally generated baud tick at sixteen times the bit rate. It confirms each start bit by a three-sample vote near the middle of the bit. It shifts in 8 or 9 data bits, least significant bit first, and checks the stop bit. It then commits the character, with its ninth bit and framing status, into a two-entry holding queue that software drains through a read port.

In 9-bit mode with address filtering switched on, only characters whose ninth bit is 1 are kept. These are the address characters, so a node only sees traffic meant to select a station. Once software recognises its own address, it turns filtering off and takes every following character. The line can be inverted before sampling. A ready flag, gated by an interrupt enable, tells software there is something to read. An overrun, caused by a character arriving while the queue is full, freezes reception until the receiver is disabled and enabled again.

Top module: `uart_addr_rx`

## Requirements
- R1: While `rxEnable` is 0, no character is received, the queue is emptied (`rxReady` = 0) and the overrun flag is cleared.
- R2: In 8-bit mode (`nineBit` = 0), a frame is one low start bit, 8 data bits LSB first and a stop bit, each 16 baud ticks long. After the stop bit the byte appears on `dataOut` and `rxReady` is 1, with `statusWord[0]` = 0.
- R3: In 9-bit mode, 9 data bits are received. The ninth is reported on `statusWord[0]` for the character at the head of the queue, and the low 8 bits on `dataOut`.
- R4: With `invertRx` = 1, the input is inverted before start detection and sampling (idle level low).
- R5: A stop bit sampled low sets `statusWord[1]` (framing error) for that character only.
- R6: `rxIrq` is 1 exactly when `rxReady` is 1 and `intEnable` is 1.
- R7: With `nineBit` = 1 and `addrDetect` = 1, a character whose ninth bit is 0 is discarded and leaves `rxReady` unchanged. A character whose ninth bit is 1 is queued.
- R8: With `addrDetect` = 0, every received character is queued, whatever its ninth bit.
- R9: The queue holds two characters. A character that completes while the queue is full and not being popped is lost and sets `statusWord[2]` (overrun). The queued characters are kept.
- R10: While overrun is set, no new character is received. Overrun stays set until `rxEnable` is cleared.
- R11: A one-cycle pulse on `popData` removes the head character. `rxReady` clears when the queue becomes empty, and a pop on an empty queue has no effect.
- R12: A low pulse shorter than the vote window (three ticks) is rejected as a false start and produces no character.
- R13: If a pop and a character commit fall in the same cycle while the queue is full, the new character is kept and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial input line |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxEnable | input | 1 | Receiver enable; clearing it flushes the queue and overrun |
| nineBit | input | 1 | Select 9 data bits per character |
| addrDetect | input | 1 | Keep only characters with ninth bit 1 (9-bit mode) |
| invertRx | input | 1 | Invert the serial input |
| intEnable | input | 1 | Receive interrupt enable |
| popData | input | 1 | Read strobe; removes the head character |
| dataOut | output | 8 | Low data bits of the head character |
| statusWord | output | 3 | [2] overrun, [1] framing error of head, [0] ninth bit of head |
| rxReady | output | 1 | Queue not empty |
| rxIrq | output | 1 | Receive interrupt |

## Verification
A software pop and a character commit can land in the same clock cycle while the queue is full. This decides whether the new character is kept or counted as an overrun. The bench first measures, from the ports alone, the cycle offset between the start of a frame and the rise of `rxReady` into an empty queue. It then fills the queue and sends a third, identically aligned frame while pulsing `popData` in exactly that cycle. It judges the result by an overrun flag that stays clear and by the order of the two characters read back afterwards.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shift;    // sample bitVal into the shift register
    logic bitVal;   // sampled line level
    logic done;     // frame finished, commit candidate
    logic stopBad;  // stop bit was low
  } rxStrobe_t;

endpackage

// File: rtl/uart_addr_rx_ctrl.sv
module uart_addr_rx_ctrl
  import uart_addr_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxIn,
  input  logic      baudTick,
  input  logic      enable,
  input  logic      nineBit,
  input  logic      invert,
  input  logic      ovrIn,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] VOTE_A = CNT_W'(OSR / 2 - 2);
  localparam logic [CNT_W-1:0] VOTE_B = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);

  rxState_t         state;
  logic [1:0]       syncQ;
  logic             line;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [1:0]       votes;
  logic             startOk;

  assign line    = syncQ[1];
  assign lastIdx = nineBit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  // majority of three: at least two samples low confirms the start bit
  assign startOk = ((!votes[0]) && (!votes[1])) || ((!votes[0]) && (!line)) ||
                   ((!votes[1]) && (!line));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= 2'b11;
    end else begin
      syncQ <= {syncQ[0], rxIn ^ invert};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      votes   <= 2'b11;
    end else if (baudTick) begin
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          bitIdx  <= '0;
          if (!line && !ovrIn) begin
            state <= ST_START;
          end
        end
        ST_START: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == VOTE_A) votes[0] <= line;
          if (tickCnt == VOTE_B) votes[1] <= line;
          if (tickCnt == MID_C) begin
            tickCnt <= '0;
            state   <= startOk ? ST_DATA : ST_IDLE;
          end
        end
        ST_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == LAST_C) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + 1'b1;
            if (bitIdx == lastIdx) state <= ST_STOP;
          end
        end
        ST_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == LAST_C) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.bitVal  = line;
    stb.stopBad = !line;
    stb.shift   = enable && baudTick && (state == ST_DATA) && (tickCnt == LAST_C);
    stb.done    = enable && baudTick && (state == ST_STOP) && (tickCnt == LAST_C);
  end

  // R10
  no_start_in_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && ovrIn) |=> (state == ST_IDLE));

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_addr_rx_dpath.sv
module uart_addr_rx_dpath
  import uart_addr_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              enable,
  input  logic              nineBit,
  input  logic              addrDetect,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic              headFrameErr,
  output logic              headBit9,
  output logic              ovr,
  output logic              ready
);

  localparam int ENT_W = DATA_W + 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [DATA_W:0]    shiftReg;
  logic [ENT_W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               charBit9;
  logic [DATA_W-1:0]  charData;
  logic               keep, full, popOk, pushOk, ovrSet;

  assign charBit9 = nineBit ? shiftReg[DATA_W] : 1'b0;
  assign charData = nineBit ? shiftReg[DATA_W-1:0] : shiftReg[DATA_W:1];
  assign keep     = !(nineBit && addrDetect && !charBit9);
  assign full     = (count == FULL_C);
  assign popOk    = pop && (count != '0);
  assign pushOk   = stb.done && keep && (!full || popOk);
  assign ovrSet   = stb.done && keep && full && !popOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.shift) begin
      shiftReg <= {stb.bitVal, shiftReg[DATA_W:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) begin
      mem[wrPtr] <= {stb.stopBad, charBit9, charData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      if (pushOk && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushOk) count <= count - 1'b1;
      if (ovrSet) ovr <= 1'b1;
    end
  end

  assign headData     = mem[rdPtr][DATA_W-1:0];
  assign headBit9     = mem[rdPtr][DATA_W];
  assign headFrameErr = mem[rdPtr][DATA_W+1];
  assign ready        = (count != '0);

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_C);

  // R10
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovr && enable) |=> ovr);

  // R1
  off_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |=> (count == '0 && !ovr));

  // R7
  addr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && stb.done && nineBit && addrDetect && !shiftReg[DATA_W] && !pop)
      |=> ($stable(count) && $stable(ovr)));

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_addr_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              baudTick,
  input  logic              rxEnable,
  input  logic              nineBit,
  input  logic              addrDetect,
  input  logic              invertRx,
  input  logic              intEnable,
  input  logic              popData,
  output logic [DATA_W-1:0] dataOut,
  output logic [2:0]        statusWord,
  output logic              rxReady,
  output logic              rxIrq
);

  rxStrobe_t stb;
  logic      ovr, headFrameErr, headBit9;

  uart_addr_rx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .baudTick (baudTick),
    .enable   (rxEnable),
    .nineBit  (nineBit),
    .invert   (invertRx),
    .ovrIn    (ovr),
    .stb      (stb)
  );

  uart_addr_rx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .enable       (rxEnable),
    .nineBit      (nineBit),
    .addrDetect   (addrDetect),
    .pop          (popData),
    .headData     (dataOut),
    .headFrameErr (headFrameErr),
    .headBit9     (headBit9),
    .ovr          (ovr),
    .ready        (rxReady)
  );

  assign statusWord = {ovr, headFrameErr && rxReady, headBit9 && rxReady};
  assign rxIrq      = rxReady && intEnable;

endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick;
  logic       rxEnable = 1'b0, nineBit = 1'b0, addrDetect = 1'b0;
  logic       invertRx = 1'b0, intEnable = 1'b0, popData = 1'b0;
  logic [7:0] dataOut;
  logic [2:0] statusWord;
  logic       rxReady, rxIrq;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int startCyc = -1;
  int offset = 0;
  logic [1:0] divCnt = '0;

  localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks

  uart_addr_rx u_dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .rxEnable(rxEnable), .nineBit(nineBit), .addrDetect(addrDetect),
    .invertRx(invertRx), .intEnable(intEnable), .popData(popData),
    .dataOut(dataOut), .statusWord(statusWord), .rxReady(rxReady), .rxIrq(rxIrq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) divCnt <= divCnt + 1'b1;
  assign baudTick = (divCnt == 2'd0);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic lvl);
    rxIn = lvl ^ invertRx;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendChar(input logic [8:0] ch, input int nb, input logic stopLvl);
    @(negedge clk);
    while (divCnt != 2'd1) @(negedge clk);
    startCyc = cyc;
    driveBit(1'b0);
    for (int i = 0; i < nb; i++) driveBit(ch[i]);
    driveBit(stopLvl);
    driveBit(1'b1);
  endtask

  task automatic popOne();
    @(negedge clk);
    popData = 1'b1;
    @(negedge clk);
    popData = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset ready", rxReady, 0);
    check("R1 reset irq", rxIrq, 0);
    check("R1 reset status", statusWord, 0);
  endtask

  task automatic t_basic8();
    intEnable = 1'b1;
    sendChar(9'h0A5, 8, 1'b1);
    check("R2 data", dataOut, 8'hA5);
    check("R2 ready", rxReady, 1);
    check("R2 status", statusWord, 0);
    check("R6 irq on", rxIrq, 1);
    intEnable = 1'b0;
    @(negedge clk);
    check("R6 irq masked", rxIrq, 0);
    popOne();
    check("R11 ready clears", rxReady, 0);
  endtask

  task automatic t_nine();
    nineBit = 1'b1;
    sendChar(9'h13C, 9, 1'b1);
    check("R3 data", dataOut, 8'h3C);
    check("R3 bit9 set", statusWord[0], 1);
    popOne();
    sendChar(9'h0C3, 9, 1'b1);
    check("R3 data b", dataOut, 8'hC3);
    check("R3 bit9 clear", statusWord[0], 0);
    popOne();
    nineBit = 1'b0;
  endtask

  task automatic t_invert();
    invertRx = 1'b1;
    rxIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    sendChar(9'h096, 8, 1'b1);
    check("R4 inverted data", dataOut, 8'h96);
    check("R4 inverted ready", rxReady, 1);
    popOne();
    invertRx = 1'b0;
    rxIn = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic t_frame();
    sendChar(9'h05A, 8, 1'b0);
    repeat (2 * BIT_CLKS) @(negedge clk);
    check("R5 data", dataOut, 8'h5A);
    check("R5 frame err", statusWord[1], 1);
    popOne();
    sendChar(9'h077, 8, 1'b1);
    check("R5 next clean", statusWord[1], 0);
    popOne();
  endtask

  task automatic t_addr();
    nineBit = 1'b1;
    addrDetect = 1'b1;
    sendChar(9'h042, 9, 1'b1);
    check("R7 data dropped", rxReady, 0);
    sendChar(9'h142, 9, 1'b1);
    check("R7 address kept", rxReady, 1);
    check("R7 address data", dataOut, 8'h42);
    popOne();
    addrDetect = 1'b0;
    sendChar(9'h055, 9, 1'b1);
    check("R8 data accepted", rxReady, 1);
    check("R8 data value", dataOut, 8'h55);
    popOne();
    nineBit = 1'b0;
  endtask

  task automatic t_overrun();
    sendChar(9'h0A1, 8, 1'b1);
    sendChar(9'h0A2, 8, 1'b1);
    check("R9 no ovr yet", statusWord[2], 0);
    sendChar(9'h0A3, 8, 1'b1);
    check("R9 ovr set", statusWord[2], 1);
    check("R9 head kept", dataOut, 8'hA1);
    popOne();
    check("R9 second kept", dataOut, 8'hA2);
    popOne();
    check("R9 empty", rxReady, 0);
    sendChar(9'h0A4, 8, 1'b1);
    check("R10 blocked rx", rxReady, 0);
    check("R10 ovr sticky", statusWord[2], 1);
    rxEnable = 1'b0;
    repeat (2) @(negedge clk);
    rxEnable = 1'b1;
    @(negedge clk);
    check("R10 ovr cleared", statusWord[2], 0);
    sendChar(9'h0A5, 8, 1'b1);
    check("R10 rx resumes", dataOut, 8'hA5);
    popOne();
  endtask

  task automatic t_emptyPop();
    popOne();
    check("R11 empty pop ready", rxReady, 0);
    check("R11 empty pop status", statusWord, 0);
    sendChar(9'h0E1, 8, 1'b1);
    check("R11 after empty pop", dataOut, 8'hE1);
    popOne();
    check("R11 single pop empties", rxReady, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    rxIn = 1'b0;
    repeat (12) @(negedge clk);
    rxIn = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R12 glitch rejected", rxReady, 0);
  endtask

  task automatic t_disabled();
    rxEnable = 1'b0;
    sendChar(9'h0C7, 8, 1'b1);
    check("R1 disabled ignored", rxReady, 0);
    rxEnable = 1'b1;
  endtask

  task automatic t_collide();
    int riseCyc;
    fork
      sendChar(9'h011, 8, 1'b1);
      begin
        @(negedge clk);
        while (!rxReady) @(negedge clk);
        riseCyc = cyc;
      end
    join
    offset = riseCyc - startCyc;
    popOne();
    sendChar(9'h021, 8, 1'b1);
    sendChar(9'h022, 8, 1'b1);
    startCyc = -1;
    fork
      sendChar(9'h023, 8, 1'b1);
      begin
        @(negedge clk);
        while (startCyc < 0) @(negedge clk);
        while (cyc != startCyc + offset - 1) @(negedge clk);
        popData = 1'b1;
        @(negedge clk);
        popData = 1'b0;
      end
    join
    check("R13 no overrun", statusWord[2], 0);
    check("R13 head after pop", dataOut, 8'h22);
    popOne();
    check("R13 new char kept", dataOut, 8'h23);
    popOne();
    check("R13 drained", rxReady, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    join_none
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    rxEnable = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    t_basic8();
    t_nine();
    t_invert();
    t_frame();
    t_addr();
    t_overrun();
    t_emptyPop();
    t_glitch();
    t_disabled();
    t_collide();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule